// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a 64-entry, 36-bit first-in first-out queue. Its write port and its read port run on clocks that need not be related. A producer pushes words with a write strobe on the write clock. A consumer pops them with a read strobe on the read clock. Each popped word lands in an output register, which keeps its value until the next successful read.

The write port sees two status flags, full and almost-full. The read port sees empty and almost-empty. All four flags are active low and are derived from Gray-coded pointers. Each pointer crosses into the other clock domain through two register stages. A single threshold offset X applies to both almost flags. It is chosen from four presets by a 2-bit select when reset is released. The system uses the almost flags to throttle bursts ahead of the hard limits.

Reset is asynchronous and active low. It must stay low for at least four edges of each clock.

Top module: `dcf_fifo`

## Requirements
- R1: While `rstN` is low, and until the second rising edge of the respective clock after it rises, `fullN` is 0 and `almostFullN` is 1 on the write side, and `emptyN` and `almostEmptyN` are 0 on the read side. `rdData` is 0 during reset.
- R2: With the FIFO empty, `fullN` becomes 1 right after the second rising edge of `wrClk` that follows the release of reset.
- R3: The offset X is taken from `presetSel` on the first rising edge of each clock after reset is released. The value is X = 4 × (presetSel + 1), so 00→4, 01→8, 10→12 and 11→16. Later changes of `presetSel` have no effect until the next reset.
- R4: `almostEmptyN` is 0 when the read side sees X or fewer stored words and 1 when it sees X+1 or more.
- R5: `almostFullN` is 0 when the write side sees 64−X or more stored words and 1 when it sees 63−X or fewer.
- R6: `fullN` is 0 when 64 words are stored. A write strobe sampled while `fullN` is 0 stores nothing and does not move the write pointer.
- R7: A read strobe sampled while `emptyN` is 0 moves nothing, and `rdData` keeps its value.
- R8: After a write into an empty FIFO, `emptyN` stays 0 after the first rising edge of `rdClk` and is 1 after the second. The earliest read that can deliver the word is on the third edge.
- R9: Each read accepted at a `rdClk` edge loads the oldest stored word into `rdData` at that edge. Words come out in write order, and `rdData` holds between reads.
- R10: After a read from a full FIFO, `fullN` is still 0 after the first following `wrClk` edge and is 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| presetSel | input | 2 | Threshold preset select, sampled after reset release |
| wrEn | input | 1 | Write strobe |
| wrData | input | 36 | Word to store |
| fullN | output | 1 | Low when no entry is free (write clock) |
| almostFullN | output | 1 | Low when at least 64−X words are stored (write clock) |
| rdEn | input | 1 | Read strobe |
| rdData | output | 36 | Output register holding the last word read |
| emptyN | output | 1 | Low when no word can be read (read clock) |
| almostEmptyN | output | 1 | Low when X or fewer words are stored (read clock) |

## Verification
The properties assume that reset is held for at least a few edges of both clocks. They also assume that `presetSel` is steady from before reset release until the first edge of each clock, so that both domains capture the same offset. The bench asserts reset away from any clock edge and holds the select across the release. It changes the select only after both domains have captured it. The write and read clocks are placed so that their rising edges never coincide, which makes the two-edge crossing latency deterministic. Strobes change only on falling edges of their own clock.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Accepted-transfer strobes from control to datapath.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } dcfStrobe_t;

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SEL_W       = 2,
  parameter int OFFSET_STEP = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  presetSel,
  input  logic              wrEn,
  input  logic              rdEn,
  output dcfStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] offsetOf(input logic [SEL_W-1:0] sel);
    return PW'((32'(sel) + 32'd1) * 32'(OFFSET_STEP));
  endfunction

  // ---------------- write domain ----------------
  logic [1:0]    wrWake;
  logic [PW-1:0] wrOffset;
  logic [PW-1:0] wrBin, wrGray, rdGrayW, rdBinW, wrFill;
  logic          wrAccept;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrWake <= '0;
    else       wrWake <= {wrWake[0], 1'b1};
  end

  // Offset follows the select until the first edge after release, then locks.
  always_ff @(posedge wrClk) begin
    if (!wrWake[0]) wrOffset <= offsetOf(presetSel);
  end

  dcf_sync2 #(.WIDTH(PW)) rdToWr_i (
    .clk (wrClk),
    .rstN(rstN),
    .d   (rdGray),
    .q   (rdGrayW)
  );

  assign rdBinW   = toBin(rdGrayW);
  assign wrFill   = wrBin - rdBinW;
  assign fullN    = wrWake[1] & (wrFill != DEPTH_P);
  assign almostFullN = ~wrWake[1] | (wrFill < (DEPTH_P - wrOffset));
  assign wrAccept = wrEn & fullN;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrAccept) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  // ---------------- read domain ----------------
  logic [1:0]    rdWake;
  logic [PW-1:0] rdOffset;
  logic [PW-1:0] rdBin, rdGray, wrGrayR, wrBinR, rdFill;
  logic          rdAccept;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdWake <= '0;
    else       rdWake <= {rdWake[0], 1'b1};
  end

  always_ff @(posedge rdClk) begin
    if (!rdWake[0]) rdOffset <= offsetOf(presetSel);
  end

  dcf_sync2 #(.WIDTH(PW)) wrToRd_i (
    .clk (rdClk),
    .rstN(rstN),
    .d   (wrGray),
    .q   (wrGrayR)
  );

  assign wrBinR       = toBin(wrGrayR);
  assign rdFill       = wrBinR - rdBin;
  assign emptyN       = rdWake[1] & (rdFill != '0);
  assign almostEmptyN = rdWake[1] & (rdFill > rdOffset);
  assign rdAccept     = rdEn & emptyN;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdAccept) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];
  assign strobe = '{wrStb: wrAccept, rdStb: rdAccept};

endmodule

// File: rtl/dcf_datapath.sv
module dcf_datapath
  import dcf_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  dcfStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdStb) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 6,
  parameter int SEL_W       = 2,
  parameter int OFFSET_STEP = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  presetSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              fullN,
  output logic              almostFullN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyN,
  output logic              almostEmptyN
);

  dcfStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  dcf_ctrl #(
    .ADDR_W     (ADDR_W),
    .SEL_W      (SEL_W),
    .OFFSET_STEP(OFFSET_STEP)
  ) ctrl_i (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .presetSel   (presetSel),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .strobe      (strobe),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .fullN       (fullN),
    .almostFullN (almostFullN),
    .emptyN      (emptyN),
    .almostEmptyN(almostEmptyN)
  );

  dcf_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) data_i (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DATA_W = 36
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              fullN,
  input logic              almostFullN,
  input logic              emptyN,
  input logic              almostEmptyN,
  input logic [DATA_W-1:0] rdData
);

  logic [1:0] wrSeen, rdSeen;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)               wrSeen <= '0;
    else if (wrSeen != 2'd2) wrSeen <= wrSeen + 2'd1;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)               rdSeen <= '0;
    else if (rdSeen != 2'd2) rdSeen <= rdSeen + 2'd1;
  end

  // R1
  wr_reset_level_chk: assert property (@(posedge wrClk)
    (wrSeen != 2'd2) |-> (!fullN && almostFullN));

  // R1
  rd_reset_level_chk: assert property (@(posedge rdClk)
    (rdSeen != 2'd2) |-> (!emptyN && !almostEmptyN));

  // R2
  full_release_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrSeen == 2'd1) |=> fullN);

  // R7
  empty_hold_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdData));

  // R6
  full_in_af_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrSeen == 2'd2 && !fullN) |-> !almostFullN);

  // R4
  empty_in_ae_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);

endmodule

bind dcf_fifo dcf_fifo_chk #(.DATA_W(DATA_W)) chk_i (
  .wrClk       (wrClk),
  .rdClk       (rdClk),
  .rstN        (rstN),
  .fullN       (fullN),
  .almostFullN (almostFullN),
  .emptyN      (emptyN),
  .almostEmptyN(almostEmptyN),
  .rdData      (rdData)
);

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 20;

  logic        wrClk = 1'b0;
  logic        rdClk = 1'b0;
  logic        rstN  = 1'b1;
  logic [1:0]  presetSel = 2'b00;
  logic        wrEn = 1'b0;
  logic [35:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        fullN, almostFullN, emptyN, almostEmptyN;
  logic [35:0] rdData;

  int checks = 0;
  int fails  = 0;
  logic [35:0] expQ[$];

  dcf_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .presetSel(presetSel),
    .wrEn(wrEn), .wrData(wrData), .fullN(fullN), .almostFullN(almostFullN),
    .rdEn(rdEn), .rdData(rdData), .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  // Write edges at 5+10k, read edges at 10+20k: never closer than 5 units.
  initial forever #(WR_PERIOD/2) wrClk = ~wrClk;
  initial forever #(RD_PERIOD/2) rdClk = ~rdClk;

  task automatic expectEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: pushes the word into the scoreboard when the port accepts it.
  task automatic writeWord(input logic [35:0] d, output bit acc);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d; acc = fullN;
    if (acc) expQ.push_back(d);
    @(posedge wrClk); #1;
    wrEn = 1'b0;
  endtask

  // Monitor: pops and compares whenever a read is taken.
  task automatic readWord(output bit took);
    logic [35:0] prev;
    logic [35:0] exp;
    @(negedge rdClk);
    rdEn = 1'b1; took = emptyN; prev = rdData;
    @(posedge rdClk); #1;
    rdEn = 1'b0;
    if (took) begin
      if (expQ.size() == 0) expectEq("R9 read with empty scoreboard", 1, 0);
      else begin
        exp = expQ.pop_front();
        expectEq("R9 data order", rdData, exp);
      end
    end else begin
      expectEq("R7 rdData held on empty read", rdData, prev);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge rdClk);
    repeat (3) @(posedge wrClk);
    #1;
  endtask

  task automatic doReset(input logic [1:0] sel);
    presetSel = sel; wrEn = 1'b0; rdEn = 1'b0;
    #1 rstN = 1'b0;
    expQ.delete();
    repeat (5) @(posedge wrClk);
    repeat (5) @(posedge rdClk);
    #1;
    expectEq("R1 fullN in reset", fullN, 0);
    expectEq("R1 almostFullN in reset", almostFullN, 1);
    expectEq("R1 emptyN in reset", emptyN, 0);
    expectEq("R1 almostEmptyN in reset", almostEmptyN, 0);
    expectEq("R1 rdData in reset", rdData, 0);
    @(negedge wrClk);
    rstN = 1'b1;
    @(posedge wrClk); #1;
    expectEq("R2 fullN after first edge", fullN, 0);
    @(posedge wrClk); #1;
    expectEq("R2 fullN after second edge", fullN, 1);
    repeat (3) @(posedge rdClk);
    presetSel = ~sel;  // R3: must be ignored from here on
    #1;
  endtask

  task automatic latencyRun();
    bit acc, took;
    logic [35:0] d = 36'h1_2345_6789;
    doReset(2'b00);
    writeWord(d, acc);
    expectEq("R6 write accepted", acc, 1);
    @(posedge rdClk); #1;
    expectEq("R8 emptyN after first read edge", emptyN, 0);
    @(posedge rdClk); #1;
    expectEq("R8 emptyN after second read edge", emptyN, 1);
    readWord(took);
    expectEq("R8 read on third edge taken", took, 1);
    repeat (3) @(posedge rdClk); #1;
    expectEq("R9 rdData holds between reads", rdData, d);
    expectEq("R7 emptyN after drain", emptyN, 0);
    readWord(took);
    expectEq("R7 empty read not taken", took, 0);
  endtask

  task automatic thresholdRun(input logic [1:0] sel);
    bit acc, took;
    int x = 4 * (int'(sel) + 1);
    int cnt;
    doReset(sel);
    for (int n = 1; n <= 64; n++) begin
      writeWord({4'(sel), 32'(n)} ^ 36'h9_3C3C_5A5A, acc);
      expectEq("R6 write accepted below full", acc, 1);
      if (n == 63 - x || n == 64 - x)
        expectEq("R5 almostFullN threshold", almostFullN, 64'(n < 64 - x));
      if (n == x || n == x + 1) begin
        settle();
        expectEq("R4 almostEmptyN threshold on fill", almostEmptyN, 64'(n > x));
      end
    end
    expectEq("R6 fullN at 64 words", fullN, 0);
    writeWord(36'hF_FFFF_0000, acc);
    expectEq("R6 write while full refused", acc, 0);
    readWord(took);
    expectEq("R9 read from full taken", took, 1);
    @(posedge wrClk); #1;
    expectEq("R10 fullN after first write edge", fullN, 0);
    @(posedge wrClk); #1;
    expectEq("R10 fullN after second write edge", fullN, 1);
    cnt = 63;
    while (cnt > 0) begin
      readWord(took);
      expectEq("R9 drain read taken", took, 1);
      cnt--;
      if (cnt == x || cnt == x + 1)
        expectEq("R4 almostEmptyN threshold on drain", almostEmptyN, 64'(cnt > x));
    end
    expectEq("R7 emptyN after drain", emptyN, 0);
    readWord(took);
    expectEq("R7 empty read not taken", took, 0);
  endtask

  task automatic streamRun();
    bit acc, took;
    int got = 0;
    doReset(2'b10);
    fork
      for (int i = 0; i < 100; i++) begin
        do writeWord(36'(i * 7919) ^ 36'hA_0F0F_00FF, acc); while (!acc);
      end
      while (got < 100) begin
        readWord(took);
        if (took) got++;
      end
    join
    settle();
    expectEq("R9 scoreboard empty after stream", expQ.size(), 0);
    expectEq("R7 emptyN after stream", emptyN, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    latencyRun();
    for (int s = 0; s < 4; s++) thresholdRun(2'(s));
    streamRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #(WR_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule